// File: doc/BRIEF.md
# System Clock Source Selector and Machine-Cycle Divider

This block sets the system clock and the instruction clock of a small microcontroller. A 4-bit mode register is loaded through a single-cycle write port. Its low field picks one of four oscillator sources. Its high field picks a prescale ratio of 1, 2, 4 or 8. The prescaled result is the system clock. A fixed divide-by-three stage then turns every three system clocks into one machine cycle, which is the basic execution time of one instruction.

All logic runs in one reference clock domain. Each oscillator appears as a one-cycle tick enable on `src_tick`, and both clocks leave the block as one-cycle enable strobes.

The prescaler is a two-state machine:
- `PS_ARMED`: the next selected tick fires the system strobe. It stays in `PS_ARMED` when the ratio is 1 and moves to `PS_COUNT` otherwise.
- `PS_COUNT`: selected ticks are counted until the last tick of the period, which returns the machine to `PS_ARMED`.

The divide-by-three stage is a ring of three states. Each system strobe moves it `MC_PH0`→`MC_PH1`→`MC_PH2`→`MC_PH0`, and the strobe that leaves `MC_PH2` also raises the machine-cycle strobe.

A write that changes the register value sends both machines back to `PS_ARMED` and `MC_PH0`. This is the clear transition, and it takes priority over every other transition.

Top module: `sysclk_sel_div`

## Requirements
- R1: `mode_q[1:0]` selects the source tick: 0 selects `src_tick[0]` (internal fast oscillator), 1 selects `src_tick[1]` (main external clock), 2 selects `src_tick[2]` (external low-frequency crystal) and 3 selects `src_tick[3]` (internal slow oscillator).
- R2: `mode_q[3:2]` selects the ratio: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8. Successive `sys_stb` pulses are spaced by the ratio times the selected source's tick period.
- R3: After reset `mode_q` is 4'b1100, which selects the internal fast oscillator divided by 8.
- R4: `sys_stb` is raised only in a cycle with a selected source tick. It is raised on the first selected tick after reset or after a clear, and then on every Nth selected tick. Ticks of sources that are not selected have no effect.
- R5: `mc_stb` is a one-cycle pulse that occurs together with every third `sys_stb` counted from reset or from a clear.
- R6: A write whose data differs from `mode_q` suppresses both strobes in its own cycle and clears the prescaler and the divide-by-three stage. The first `sys_stb` after the write falls on the first tick of the new source after the write cycle.
- R7: A write whose data equals `mode_q` has no effect on the strobes or on the counting.
- R8: `mode_q` shows the register value and takes the written data in the cycle after a changing write. Without a write it does not change.
- R9: All 16 codes are legal, and each gives a distinct source and ratio pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 4 | Mode value to write |
| src_tick | input | 4 | One-cycle tick enables of the four sources |
| sys_stb | output | 1 | System clock enable strobe |
| mc_stb | output | 1 | Machine-cycle (instruction clock) strobe |
| mode_q | output | 4 | Read-back of the mode register |

## Verification
The four source ticks run at pairwise different periods of 2, 3, 5 and 7 cycles. This gives the 16 codes 16 different strobe spacings, so a wrong source bit or a wrong ratio bit changes the measured interval. Each code is entered by a write at an arbitrary phase of the previous setting, which tells a correct clear on switch apart from a leftover count. Further runs mask the selected source while the others keep ticking, and repeat writes of the unchanged value in the middle of a period. These separate "ignored" from "cleared" behaviour.

// File: rtl/sck_pkg.sv
package sck_pkg;

    typedef enum logic {
        PS_ARMED = 1'b0,
        PS_COUNT = 1'b1
    } ps_state_t;

    typedef enum logic [1:0] {
        MC_PH0 = 2'd0,
        MC_PH1 = 2'd1,
        MC_PH2 = 2'd2
    } mc_state_t;

endpackage

// File: rtl/sck_src_pick.sv
module sck_src_pick #(
    parameter int SEL_W   = 2,
    parameter int NUM_SRC = 1 << SEL_W
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick_out
);

    logic [NUM_SRC-1:0] hit;

    // one-hot gating of each source by its select code
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
    end

    assign tick_out = |hit;

endmodule

// File: rtl/sck_prescale.sv
module sck_prescale
    import sck_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [DIV_W-1:0] ratio_sel,
    output logic             stb
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    ps_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'((1 << ratio_sel) - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_ARMED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        stb   = 1'b0;
        if (clr) begin
            st_d  = PS_ARMED;
            cnt_d = '0;
        end else if (tick) begin
            unique case (st_q)
                PS_ARMED: begin
                    stb = 1'b1;
                    if (last != '0) begin
                        st_d  = PS_COUNT;
                        cnt_d = CNT_W'(1);
                    end
                end
                PS_COUNT: begin
                    if (cnt_q == last) begin
                        st_d  = PS_ARMED;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = PS_ARMED;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // R4: a system strobe needs a selected tick
    p_stb_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> tick);

    // R6: a clear always re-arms the prescaler
    p_clr_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == PS_ARMED && cnt_q == '0));

endmodule

// File: rtl/sck_div3.sv
module sck_div3
    import sck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sys_stb,
    output logic mc_stb
);

    mc_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MC_PH0;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        mc_stb = 1'b0;
        if (clr) begin
            st_d = MC_PH0;
        end else if (sys_stb) begin
            unique case (st_q)
                MC_PH0:  st_d = MC_PH1;
                MC_PH1:  st_d = MC_PH2;
                MC_PH2: begin
                    st_d   = MC_PH0;
                    mc_stb = 1'b1;
                end
                default: st_d = MC_PH0;
            endcase
        end
    end

    // R5: machine-cycle pulse only together with a system strobe
    p_mc_with_sys_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |-> sys_stb);

    // R5: a machine-cycle pulse restarts the group of three
    p_mc_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |=> st_q == MC_PH0);

endmodule

// File: rtl/sysclk_sel_div.sv
module sysclk_sel_div #(
    parameter int SEL_W      = 2,
    parameter int DIV_W      = 2,
    parameter int MODE_W     = SEL_W + DIV_W,
    parameter int NUM_SRC    = 1 << SEL_W,
    parameter int RESET_MODE = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [MODE_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               sys_stb,
    output logic               mc_stb,
    output logic [MODE_W-1:0]  mode_q
);

    localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(RESET_MODE);

    logic mode_chg;
    logic sel_tick;

    assign mode_chg = wr_en && (wr_data != mode_q);

    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_RST;
        else if (mode_chg) mode_q <= wr_data;
    end

    sck_src_pick #(
        .SEL_W   (SEL_W),
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .src_tick (src_tick),
        .sel      (mode_q[SEL_W-1:0]),
        .tick_out (sel_tick)
    );

    sck_prescale #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mode_chg),
        .tick      (sel_tick),
        .ratio_sel (mode_q[MODE_W-1:SEL_W]),
        .stb       (sys_stb)
    );

    sck_div3 u_div3 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg),
        .sys_stb (sys_stb),
        .mc_stb  (mc_stb)
    );

    // R6: no strobe in the cycle of a changing write
    p_no_stb_on_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> !sys_stb && !mc_stb);

    // R8: a changing write is visible one cycle later
    p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> mode_q == $past(wr_data));

    // R8: without a write the register holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

endmodule

// File: tb/sim_sysclk_sel_div.sv
`timescale 1ns/1ps
module sim_sysclk_sel_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] src_tick = 4'h0;
    logic       sys_stb, mc_stb;
    logic [3:0] mode_q;

    always #4 clk = ~clk;

    sysclk_sel_div u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .src_tick(src_tick), .sys_stb(sys_stb), .mc_stb(mc_stb), .mode_q(mode_q)
    );

    int per [4] = '{2, 3, 5, 7};
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [3:0] tmask = 4'hF;

    // reference model state
    int cyc = 0;
    int m_mode = 12;
    int m_k = 0, m_s = 0;
    int mism = 0, mis_act = 0, mis_exp = 0;
    int nsys = 0, nmc = 0, last_sys = -1, prev_sys = -1, first_sys = -1;
    int ivl [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic win_reset();
        mism = 0; nsys = 0; nmc = 0;
        last_sys = -1; prev_sys = -1; first_sys = -1;
    endtask

    task automatic step(input bit we, input logic [3:0] d);
        bit chg, e_sys, e_mc;
        int ratio;
        @(negedge clk);
        wr_en = we;
        wr_data = d;
        for (int i = 0; i < 4; i++) src_tick[i] = tmask[i] && ((cyc % per[i]) == 0);
        #1;
        chg = we && (int'(d) != m_mode);
        ratio = 1 << (m_mode / 4);
        e_sys = 1'b0;
        e_mc = 1'b0;
        if (!chg && src_tick[m_mode % 4]) begin
            e_sys = (m_k % ratio) == 0;
            if (e_sys) begin
                e_mc = (m_s % 3) == 2;
                m_s++;
            end
            m_k++;
        end
        if (sys_stb !== e_sys || mc_stb !== e_mc) begin
            if (mism == 0) begin
                mis_act = {sys_stb, mc_stb};
                mis_exp = {e_sys, e_mc};
            end
            mism++;
        end
        if (sys_stb === 1'b1) begin
            prev_sys = last_sys;
            last_sys = cyc;
            if (first_sys < 0) first_sys = cyc;
            nsys++;
        end
        if (mc_stb === 1'b1) nmc++;
        if (chg) begin
            m_mode = int'(d);
            m_k = 0;
            m_s = 0;
        end
        cyc++;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mode_q == 4'b1100, "R3", "reset mode", mode_q, 12);
        win_reset();
        repeat (800) step(1'b0, 4'h0);
        chk(mism == 0, "R3", "reset-mode strobe pattern", mis_act, mis_exp);
        chk(last_sys - prev_sys == 16, "R3", "reset-mode spacing", last_sys - prev_sys, 16);
        chk(nmc == nsys / 3, "R5", "reset-mode machine cycles", nmc, nsys / 3);

        // R1 R2 R6 R8: sweep every code, entered at arbitrary phase
        for (int c = 0; c < 16; c++) begin
            int wc, p, exp_ivl, exp_first;
            win_reset();
            wc = cyc;
            p = per[c % 4];
            exp_ivl = p * (1 << (c / 4));
            exp_first = wc + p - (wc % p);
            step(1'b1, 4'(c));
            repeat (700) step(1'b0, 4'h0);
            ivl[c] = last_sys - prev_sys;
            chk(mode_q == 4'(c), "R8", $sformatf("readback code %0d", c), mode_q, c);
            chk(mism == 0, "R1", $sformatf("strobe pattern code %0d", c), mis_act, mis_exp);
            chk(ivl[c] == exp_ivl, "R2", $sformatf("spacing code %0d", c), ivl[c], exp_ivl);
            chk(first_sys == exp_first, "R6", $sformatf("first strobe code %0d", c), first_sys, exp_first);
            chk(nmc == nsys / 3, "R5", $sformatf("machine cycles code %0d", c), nmc, nsys / 3);
        end

        // R9: all 16 codes give distinct timing
        for (int a = 0; a < 16; a++)
            for (int b = a + 1; b < 16; b++)
                chk(ivl[a] != ivl[b], "R9", $sformatf("codes %0d/%0d distinct", a, b), ivl[a], ivl[b]);

        // R7: same-value writes in mid period
        win_reset();
        step(1'b1, 4'b0101);
        for (int j = 0; j < 60; j++) begin
            step(1'b1, 4'b0101);
            repeat (4) step(1'b0, 4'h0);
        end
        chk(mism == 0, "R7", "same-value writes pattern", mis_act, mis_exp);
        chk(last_sys - prev_sys == 6, "R7", "same-value writes spacing", last_sys - prev_sys, 6);
        chk(nmc == nsys / 3, "R7", "same-value writes machine cycles", nmc, nsys / 3);

        // R4: unselected ticks are ignored
        step(1'b1, 4'b1110);
        tmask = 4'b1011;
        win_reset();
        repeat (300) step(1'b0, 4'h0);
        chk(nsys == 0, "R4", "no strobe with selected source idle", nsys, 0);
        chk(nmc == 0, "R4", "no machine cycle with selected source idle", nmc, 0);
        tmask = 4'hF;
        win_reset();
        repeat (300) step(1'b0, 4'h0);
        chk(mism == 0, "R4", "resumed strobe pattern", mis_act, mis_exp);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule